// File: doc/BRIEF.md
# Hierarchical Read-Strobe Delay Stepper

This block holds one read-strobe delay setting made of three nested fields. The coarse count is the outer field. The medium field is a quarter step inside one coarse unit, with four positions. The fine tap field is the innermost and has fifteen positions, 0 to 14. A calibration sequencer outside the block moves the setting with single-cycle step commands. It can step at medium granularity or at tap granularity. A step that runs past the end of a lower field carries into the next field up, and a step below zero borrows from it.

When a step cannot be made, because it would push coarse above its maximum or below zero, the block rejects it. The setting stays as it was and an error pulse lasting one cycle is raised. A separate command lowers coarse by one and leaves the lower fields alone. A parallel load writes coarse, medium, tap and a 3-bit phase-interpolator value in one cycle. The interpolator value changes only through a load. The setting is available all the time as one packed vector. The sequencer uses that vector to program the strobe delay line while it searches for the strobe preamble.

Top module: `strobe_delay_stepper`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears coarse, medium, tap, the interpolator value and `err_o` to 0.
- R2: A medium-up step (command code 1) adds 1 to medium when medium is below 3. At medium 3 it sets medium to 0 and adds 1 to coarse. Tap does not change.
- R3: A medium-up step at medium 3 with coarse 15 is rejected. Coarse, medium and tap keep their values.
- R4: A medium-down step (code 2) subtracts 1 from medium when medium is above 0. At medium 0 it sets medium to 3 and subtracts 1 from coarse. At medium 0 with coarse 0 it is rejected and nothing changes.
- R5: A tap-up step (code 3) adds 1 to tap when tap is below 14. At tap 14 it clears tap to 0 and performs a medium-up step. If that medium-up step would be rejected, the whole tap-up step is rejected and nothing changes.
- R6: A tap-down step (code 4) subtracts 1 from tap when tap is above 0. At tap 0 it sets tap to 14 and performs a medium-down step. If that medium-down step would be rejected, the whole tap-down step is rejected and nothing changes.
- R7: A coarse-down step (code 5) subtracts 1 from coarse and leaves medium and tap unchanged. At coarse 0 it is rejected.
- R8: When `load_i` is high, the block writes all four load fields in that cycle and ignores `cmd_i`. A load never raises `err_o`. A loaded tap above 14 is stored as 14.
- R9: The interpolator output changes only on a load. Step commands never change it.
- R10: `err_o` is high for exactly the one cycle that follows the clock edge at which a step was rejected, and is low at every other time. Codes 0, 6 and 7 have no effect.
- R11: `setting_o` packs the fields with coarse in bits 9:6, medium in bits 5:4 and tap in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_i | input | 3 | Step command code, sampled every cycle |
| load_i | input | 1 | Parallel load strobe; has priority over `cmd_i` |
| ld_coarse_i | input | 4 | Coarse value to load |
| ld_medium_i | input | 2 | Medium value to load |
| ld_tap_i | input | 4 | Tap value to load; values above 14 are stored as 14 |
| ld_pi_i | input | 3 | Interpolator value to load |
| setting_o | output | 10 | Packed {coarse, medium, tap} |
| pi_o | output | 3 | Current interpolator value |
| err_o | output | 1 | One-cycle pulse that follows a rejected step |

## Verification
The tests run directed walks of each step type through its carry and borrow boundaries. A medium walk from medium 0 that crosses into the next coarse unit shows whether the wrap happens at 3. Tap walks across tap 14 and tap 0 show whether the fifteen-position wrap feeds the right medium step. Loads at the extreme corners (coarse 15, medium 3, tap 14 and the all-zero setting) show whether a rejected step really leaves the setting frozen, and whether the error comes from the right chain. A long pseudo-random mix of loads, all eight command codes and commands issued together with loads is then compared cycle by cycle against a behavioural model. This mix separates load priority from step handling, and shows that the interpolator value is left alone by steps.

// File: rtl/dly_step_pkg.sv
// Package: shared command encoding for the delay stepper.
// Assumes commands arrive as a 3-bit code; unused codes mean no operation.
package dly_step_pkg;
    typedef enum logic [2:0] {
        STEP_NONE     = 3'd0,
        STEP_MED_UP   = 3'd1,
        STEP_MED_DN   = 3'd2,
        STEP_TAP_UP   = 3'd3,
        STEP_TAP_DN   = 3'd4,
        STEP_COARSE_DN = 3'd5
    } step_cmd_e;
endpackage

// File: rtl/dly_medium_step.sv
// Module: one quarter step on the {coarse, medium} pair, up or down.
// Carries into or borrows from coarse at the ends of the medium range.
// Flags a failure when coarse would leave the range 0 to COARSE_MAX.
// Assumes medium never holds a value above MED_MAX.
module dly_medium_step #(
    parameter int CW         = 4,
    parameter int COARSE_MAX = 15,
    parameter int MW         = 2,
    parameter int MED_MAX    = 3
) (
    input  logic [CW-1:0] coarse_i,
    input  logic [MW-1:0] medium_i,
    input  logic          up_i,
    output logic [CW-1:0] coarse_o,
    output logic [MW-1:0] medium_o,
    output logic          fail_o
);
    localparam logic [CW-1:0] C_TOP = CW'(COARSE_MAX);
    localparam logic [MW-1:0] M_TOP = MW'(MED_MAX);

    // Purpose: next {coarse, medium} for a single quarter step, plus failure flag.
    always_comb begin
        coarse_o = coarse_i;
        medium_o = medium_i;
        fail_o   = 1'b0;
        if (up_i) begin
            if (medium_i != M_TOP) begin
                medium_o = medium_i + MW'(1);
            end else if (coarse_i != C_TOP) begin
                medium_o = '0;
                coarse_o = coarse_i + CW'(1);
            end else begin
                fail_o = 1'b1;
            end
        end else begin
            if (medium_i != '0) begin
                medium_o = medium_i - MW'(1);
            end else if (coarse_i != '0) begin
                medium_o = M_TOP;
                coarse_o = coarse_i - CW'(1);
            end else begin
                fail_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dly_tap_step.sv
// Module: one fine step on the tap field, which wraps at TAP_MAX rather
// than at a power of two. The wrap flag asks the parent for a medium step.
// Assumes tap never holds a value above TAP_MAX.
module dly_tap_step #(
    parameter int TW      = 4,
    parameter int TAP_MAX = 14
) (
    input  logic [TW-1:0] tap_i,
    input  logic          up_i,
    output logic [TW-1:0] tap_o,
    output logic          wrap_o
);
    localparam logic [TW-1:0] T_TOP = TW'(TAP_MAX);

    // Purpose: next tap value and the flag that signals a wrap.
    always_comb begin
        wrap_o = 1'b0;
        if (up_i) begin
            if (tap_i == T_TOP) begin
                tap_o  = '0;
                wrap_o = 1'b1;
            end else begin
                tap_o = tap_i + TW'(1);
            end
        end else begin
            if (tap_i == '0) begin
                tap_o  = T_TOP;
                wrap_o = 1'b1;
            end else begin
                tap_o = tap_i - TW'(1);
            end
        end
    end
endmodule

// File: rtl/strobe_delay_stepper.sv
// Module: holds a three-level strobe delay setting (coarse, medium, tap) and
// a phase-interpolator value. It applies one step command per cycle, with
// carry and borrow between fields, and rejects a step that cannot be made.
// A parallel load has priority over steps. Reset is synchronous, active low.
// Assumes the sequencer holds cmd_i at STEP_NONE when it has nothing to do.
module strobe_delay_stepper #(
    parameter int CW         = 4,
    parameter int COARSE_MAX = 15,
    parameter int MED_STEPS  = 4,
    parameter int TAP_MAX    = 14,
    parameter int PW         = 3,
    localparam int MW        = $clog2(MED_STEPS),
    localparam int TW        = $clog2(TAP_MAX + 1),
    localparam int SW        = CW + MW + TW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cmd_i,
    input  logic          load_i,
    input  logic [CW-1:0] ld_coarse_i,
    input  logic [MW-1:0] ld_medium_i,
    input  logic [TW-1:0] ld_tap_i,
    input  logic [PW-1:0] ld_pi_i,
    output logic [SW-1:0] setting_o,
    output logic [PW-1:0] pi_o,
    output logic          err_o
);
    import dly_step_pkg::*;

    localparam int MED_MAX = MED_STEPS - 1;

    logic [CW-1:0] coarse_q, coarse_nx, med_coarse, ld_coarse_c;
    logic [MW-1:0] medium_q, medium_nx, med_medium;
    logic [TW-1:0] tap_q, tap_nx, tap_step, ld_tap_c;
    logic [PW-1:0] pi_q;
    logic          err_q, step_fail, med_fail, med_up, tap_up, tap_wrap;
    step_cmd_e     cmd;

    assign cmd    = step_cmd_e'(cmd_i);
    assign med_up = (cmd == STEP_MED_UP) || (cmd == STEP_TAP_UP);
    assign tap_up = (cmd == STEP_TAP_UP);

    dly_medium_step #(
        .CW(CW), .COARSE_MAX(COARSE_MAX), .MW(MW), .MED_MAX(MED_MAX)
    ) u_med (
        .coarse_i(coarse_q), .medium_i(medium_q), .up_i(med_up),
        .coarse_o(med_coarse), .medium_o(med_medium), .fail_o(med_fail)
    );

    dly_tap_step #(.TW(TW), .TAP_MAX(TAP_MAX)) u_tap (
        .tap_i(tap_q), .up_i(tap_up), .tap_o(tap_step), .wrap_o(tap_wrap)
    );

    // Purpose: clamp loaded fields only where the field can hold illegal codes.
    generate
        if (COARSE_MAX < (1 << CW) - 1) begin : g_clamp_coarse
            assign ld_coarse_c = (ld_coarse_i > CW'(COARSE_MAX)) ? CW'(COARSE_MAX) : ld_coarse_i;
        end else begin : g_pass_coarse
            assign ld_coarse_c = ld_coarse_i;
        end
        if (TAP_MAX < (1 << TW) - 1) begin : g_clamp_tap
            assign ld_tap_c = (ld_tap_i > TW'(TAP_MAX)) ? TW'(TAP_MAX) : ld_tap_i;
        end else begin : g_pass_tap
            assign ld_tap_c = ld_tap_i;
        end
    endgenerate

    // Purpose: select the candidate next setting and failure for the command.
    always_comb begin
        coarse_nx = coarse_q;
        medium_nx = medium_q;
        tap_nx    = tap_q;
        step_fail = 1'b0;
        case (cmd)
            STEP_MED_UP, STEP_MED_DN: begin
                coarse_nx = med_coarse;
                medium_nx = med_medium;
                step_fail = med_fail;
            end
            STEP_TAP_UP, STEP_TAP_DN: begin
                tap_nx = tap_step;
                if (tap_wrap) begin
                    coarse_nx = med_coarse;
                    medium_nx = med_medium;
                    step_fail = med_fail;
                end
            end
            STEP_COARSE_DN: begin
                if (coarse_q == '0) step_fail = 1'b1;
                else                coarse_nx = coarse_q - CW'(1);
            end
            default: ;
        endcase
    end

    // Purpose: state register with reset, load priority and step commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q <= '0;
            medium_q <= '0;
            tap_q    <= '0;
            pi_q     <= '0;
            err_q    <= 1'b0;
        end else if (load_i) begin
            coarse_q <= ld_coarse_c;
            medium_q <= ld_medium_i;
            tap_q    <= ld_tap_c;
            pi_q     <= ld_pi_i;
            err_q    <= 1'b0;
        end else if (step_fail) begin
            err_q <= 1'b1;
        end else begin
            coarse_q <= coarse_nx;
            medium_q <= medium_nx;
            tap_q    <= tap_nx;
            err_q    <= 1'b0;
        end
    end

    assign setting_o = {coarse_q, medium_q, tap_q};
    assign pi_o      = pi_q;
    assign err_o     = err_q;

    // Requirement checks on the registered state.
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (setting_o == '0 && pi_o == '0 && !err_o));

    assert_medium_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cmd_i) == 3'd1 && !$past(load_i) && !err_o) |->
        (int'(coarse_q) * MED_STEPS + int'(medium_q) ==
         int'($past(coarse_q)) * MED_STEPS + int'($past(medium_q)) + 1));

    assert_reject_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && err_o) |-> $stable(setting_o));

    assert_tap_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tap_q <= TW'(TAP_MAX));

    assert_coarse_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cmd_i) == 3'd5 && !$past(load_i) && !err_o) |->
        ($stable(medium_q) && $stable(tap_q) && coarse_q == $past(coarse_q) - CW'(1)));

    assert_pi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_i)) |-> $stable(pi_o));

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($past(rst_n) && !$past(load_i) &&
                   $past(cmd_i) != 3'd0 && $past(cmd_i) < 3'd6));
endmodule

// File: tb/strobe_delay_stepper_bench.sv
`timescale 1ns/1ps
module strobe_delay_stepper_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_i = 3'd0;
    logic       load_i = 1'b0;
    logic [3:0] ld_coarse_i = '0;
    logic [1:0] ld_medium_i = '0;
    logic [3:0] ld_tap_i = '0;
    logic [2:0] ld_pi_i = '0;
    logic [9:0] setting_o;
    logic [2:0] pi_o;
    logic       err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    int mc = 0, mm = 0, mt = 0, mp = 0, me = 0;

    always #2 clk = ~clk;

    strobe_delay_stepper u_strobe_delay_stepper (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .load_i(load_i),
        .ld_coarse_i(ld_coarse_i), .ld_medium_i(ld_medium_i),
        .ld_tap_i(ld_tap_i), .ld_pi_i(ld_pi_i),
        .setting_o(setting_o), .pi_o(pi_o), .err_o(err_o)
    );

    task automatic med_step(input bit up, inout int c, inout int m, output bit f);
        f = 1'b0;
        if (up) begin
            if (m < 3) m++;
            else if (c < 15) begin m = 0; c++; end
            else f = 1'b1;
        end else begin
            if (m > 0) m--;
            else if (c > 0) begin m = 3; c--; end
            else f = 1'b1;
        end
    endtask

    task automatic model_edge(input int cmd, input bit ld, input int lc, input int lm,
                              input int lt, input int lp);
        int nc, nm, nt;
        bit f;
        if (ld) begin
            mc = lc; mm = lm; mt = (lt > 14) ? 14 : lt; mp = lp; me = 0;
            return;
        end
        nc = mc; nm = mm; nt = mt; f = 1'b0;
        case (cmd)
            1: med_step(1'b1, nc, nm, f);
            2: med_step(1'b0, nc, nm, f);
            3: if (nt < 14) nt++; else begin nt = 0; med_step(1'b1, nc, nm, f); end
            4: if (nt > 0) nt--; else begin nt = 14; med_step(1'b0, nc, nm, f); end
            5: if (nc > 0) nc--; else f = 1'b1;
            default: ;
        endcase
        if (f) me = 1;
        else begin me = 0; mc = nc; mm = nm; mt = nt; end
    endtask

    task automatic compare(input string req);
        int exp_set;
        exp_set = mc * 64 + mm * 16 + mt;
        checks++;
        if (int'(setting_o) != exp_set || int'(pi_o) != mp || int'(err_o) != me) begin
            errors++;
            $display("FAIL %s: setting=%0d pi=%0d err=%0d expected setting=%0d pi=%0d err=%0d",
                     req, setting_o, pi_o, err_o, exp_set, mp, me);
        end
    endtask

    // Apply one cycle of stimulus at the falling edge, check at the next falling edge.
    task automatic cyc(input int cmd, input bit ld, input int lc, input int lm,
                       input int lt, input int lp, input string req);
        cmd_i = 3'(cmd); load_i = ld;
        ld_coarse_i = 4'(lc); ld_medium_i = 2'(lm); ld_tap_i = 4'(lt); ld_pi_i = 3'(lp);
        model_edge(cmd, ld, lc, lm, lt, lp);
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    task automatic ld(input int c, input int m, input int t, input int p, input string req);
        cyc(0, 1'b1, c, m, t, p, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");

        // R8: load and R11: packing
        ld(2, 0, 0, 5, "R8");
        compare("R11");
        // R2: medium walk with carry into coarse
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, 0, "R2");
        // R3 / R5: rejects at the top corner
        ld(15, 3, 14, 1, "R8");
        cyc(1, 0, 0, 0, 0, 0, "R3");
        cyc(0, 0, 0, 0, 0, 0, "R10");
        cyc(3, 0, 0, 0, 0, 0, "R5");
        cyc(6, 0, 0, 0, 0, 0, "R10");
        cyc(4, 0, 0, 0, 0, 0, "R6");
        // R4 / R6 / R7: rejects at the bottom corner
        ld(0, 0, 0, 2, "R8");
        cyc(2, 0, 0, 0, 0, 0, "R4");
        cyc(4, 0, 0, 0, 0, 0, "R6");
        cyc(5, 0, 0, 0, 0, 0, "R7");
        cyc(7, 0, 0, 0, 0, 0, "R10");
        // Borrow and carry chains through tap
        ld(5, 0, 0, 3, "R8");
        cyc(4, 0, 0, 0, 0, 0, "R6");
        cyc(3, 0, 0, 0, 0, 0, "R5");
        cyc(2, 0, 0, 0, 0, 0, "R4");
        cyc(5, 0, 0, 0, 0, 0, "R7");
        for (int i = 0; i < 16; i++) cyc(3, 0, 0, 0, 0, 0, "R5");
        compare("R9");
        // Load priority over a command, and tap clamp
        cyc(5, 1'b1, 0, 0, 0, 0, "R8");
        cyc(5, 1'b1, 9, 2, 15, 6, "R8");
        // Pseudo-random mix
        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 400; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                cyc(int'(lf[2:0]), (lf[7:4] == 4'd0), int'(lf[11:8]), int'(lf[13:12]),
                    int'(lf[15:12]), int'(lf[6:4]), "R10");
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule